// File: doc/BRIEF.md
# Two-Wire Bus Master Bit-Timing Generator

This block turns single bus-level commands into correctly timed open-drain drive enables for the clock line (SCL) and the data line (SDA) of a two-wire bus master. It handles a start, a repeated start, one data bit and a stop. A 6-bit divider code selects an even bit period D in system clocks. The data hold time, the data setup time and the start hold time all come from that same code. The block only ever pulls a line low; the external pull-up makes the line high.

Commands arrive on a valid/ready port. `cmd_ready` is high only while the generator is idle. A command is taken on a rising clock edge where both `cmd_valid` and `cmd_ready` are high. While a command runs, `cmd_ready` stays low, and any valid that is presented is neither stored nor acted on. The producer does not need to hold `cmd_valid` in that time. The divider code is captured when a command is taken, so changing it in mid-command has no effect. Each line also passes through its own digital glitch filter, whose window is set by a rate field. The filtered levels come out as qualified line states.

Top module: `twi_bit_timer`

## Requirements
- R1: During reset and right after it, `scl_oe` and `sda_oe` are 0 (lines released), `busy` is 0, `cmd_ready` is 1, and both qualified outputs are 1.
- R2: The bit period is D = (8 + {code[5],code[1],code[0]}) << (code[4:2] + 5) clocks. In a data bit, SCL is driven low for D/2 clocks and then released for D/2 clocks.
- R3: Opcode 01 is a data bit. The hold time is Th = 8 + (16 << code[4:2]) × k, with k = 1, 2, 3, 4 for {code[5],code[1]} = 10, 11, 00, 01. For Th clocks after acceptance, SDA keeps its previous enable. It then takes `!cmd_bit`: bit 1 releases the line and bit 0 drives it low. SDA changes only while SCL is driven low.
- R4: In a data bit, SCL is released D/2 clocks after acceptance. This gives a data setup time of D/2 − Th clocks.
- R5: Opcode 00 is a start. When SCL is released at acceptance, SDA is driven low on the acceptance edge, and SCL is driven low Ts clocks later. Ts is D/16, halved until it is below 16 (code[5]=0) or below 9 (code[5]=1).
- R6: Opcode 00 with SCL driven low at acceptance is a repeated start. SDA is released and SCL stays low for D/2 clocks. SCL is then released for D/2 + Ts clocks. SDA is driven low next, and SCL is driven low Ts clocks after that.
- R7: Opcode 10 or 11 is a stop. Both lines are driven low for D/2 clocks. SCL is then released, and SDA is released 4 clocks later.
- R8: `busy` rises on the clock after acceptance and falls on the edge that applies the last line change. `cmd_ready` equals `!busy`. A valid presented while busy does not alter the running sequence. Outputs do not change while idle.
- R9: Let R be `filt_rate`. A change on a raw line input reaches its qualified output on the (2R+2)-th rising edge after the change. This is one synchronizing edge plus 2R+1 edges of stability. A pulse lasting 2R cycles or fewer never reaches the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_sel | input | 6 | Divider code, captured when a command is accepted |
| filt_rate | input | 6 | Glitch filter rate R (window 2R+1 clocks) |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Generator idle, command will be taken |
| cmd_op | input | 2 | 00 start / repeated start, 01 data bit, 10 or 11 stop |
| cmd_bit | input | 1 | Data bit value for opcode 01 |
| busy | output | 1 | Command sequence in progress |
| scl_oe | output | 1 | Drive SCL low when 1 |
| sda_oe | output | 1 | Drive SDA low when 1 |
| scl_in | input | 1 | Raw sampled SCL pin level |
| sda_in | input | 1 | Raw sampled SDA pin level |
| scl_qual | output | 1 | Filtered SCL level |
| sda_qual | output | 1 | Filtered SDA level |

## Verification
A faulty step index or interval counter shows up as a segment of the wrong length, or as a wrong pair of line enables. This becomes visible at the port on the first edge where that segment should have ended, which is at most one bit period after acceptance. A faulty saved-line flag swaps a start for a repeated start, and this shows on the acceptance edge itself. A busy flag that is wrong either lets a second command overwrite the line enables at once, or holds `cmd_ready` low past the final edge. A filter counter that is wrong moves the qualified edge off cycle 2R+2, or lets a short pulse through. Both errors can be seen within 2R+2 clocks of the raw change.

// File: rtl/twi_pkg.sv
package twi_pkg;
  parameter int LEN_W = 17;
  parameter int CODE_W = 6;

  typedef enum logic [1:0] {
    OP_START = 2'b00,
    OP_DATA  = 2'b01,
    OP_STOP  = 2'b10,
    OP_STOPX = 2'b11
  } op_e;

  typedef struct packed {
    logic [LEN_W-1:0] half;
    logic [LEN_W-1:0] hold;
    logic [LEN_W-1:0] setup;
    logic [LEN_W-1:0] sta;
  } tim_t;

  typedef struct packed {
    logic             scl_lo;
    logic             sda_lo;
    logic [LEN_W-1:0] len;
    logic             fin;
  } seg_t;
endpackage

// File: rtl/twi_div_decode.sv
module twi_div_decode
  import twi_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output tim_t              tim
);
  localparam int SH_W = 3;

  logic [3:0]       base;
  logic [SH_W-1:0]  sh;
  logic [2:0]       k;
  logic [LEN_W-1:0] d;
  logic [LEN_W-1:0] unit;
  logic [LEN_W-1:0] v;
  logic [LEN_W-1:0] lim;

  always_comb begin
    sh   = code[4:2];
    base = 4'd8 + {1'b0, code[5], code[1:0]};
    d    = LEN_W'(base) << ({2'b0, sh} + 5'd5);
    case ({code[5], code[1]})
      2'b10:   k = 3'd1;
      2'b11:   k = 3'd2;
      2'b00:   k = 3'd3;
      default: k = 3'd4;
    endcase
    unit      = LEN_W'(16) << sh;
    tim.half  = d >> 1;
    tim.hold  = LEN_W'(8) + unit * LEN_W'(k);
    tim.setup = (d >> 1) - tim.hold;
    lim = code[5] ? LEN_W'(9) : LEN_W'(16);
    v   = d >> 4;
    for (int i = 0; i < 12; i++) begin
      if (v >= lim) v = v >> 1;
    end
    tim.sta = v;
  end
endmodule

// File: rtl/twi_glitch_filter.sv
module twi_glitch_filter #(
  parameter int RATE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate,
  input  logic              raw,
  output logic              qual
);
  localparam int CW = RATE_W + 2;

  logic          sync_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_cnt;

  assign last_cnt = {1'b0, rate, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b1;
      qual   <= 1'b1;
      cnt_q  <= '0;
    end else begin
      sync_q <= raw;
      if (sync_q == qual) begin
        cnt_q <= '0;
      end else if (cnt_q == last_cnt) begin
        qual  <= sync_q;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R9: the qualified level only ever takes the synchronized value
  p_qual_from_sync_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(qual) |-> qual == $past(sync_q));

  // R9: agreement between sample and output freezes the output
  p_qual_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q == qual) |=> $stable(qual));
endmodule

// File: rtl/twi_bit_timer.sv
module twi_bit_timer
  import twi_pkg::*;
#(
  parameter int RATE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] div_sel,
  input  logic [RATE_W-1:0] filt_rate,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_bit,
  output logic              busy,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_qual,
  output logic              sda_qual
);
  localparam int NLINE = 2;

  logic              busy_q, rs_q, bit_q, scl_q, sda_q;
  op_e               op_q;
  logic [CODE_W-1:0] code_q, code_eff;
  logic [1:0]        step_q;
  logic [LEN_W-1:0]  cnt_q;
  tim_t              tim;
  seg_t              cur, nxt, first;
  logic              accept;

  assign accept    = cmd_valid && !busy_q;
  assign cmd_ready = !busy_q;
  assign busy      = busy_q;
  assign scl_oe    = scl_q;
  assign sda_oe    = sda_q;
  assign code_eff  = busy_q ? code_q : div_sel;

  twi_div_decode u_dec (.code(code_eff), .tim(tim));

  function automatic seg_t seg_of(op_e op, logic rs, logic b, logic sda_now,
                                  logic [1:0] st, tim_t t);
    seg_t s;
    s = '0;
    s.len = LEN_W'(1);
    case (op)
      OP_START: begin
        if (!rs) begin
          case (st)
            2'd0:    begin s.sda_lo = 1'b1; s.len = t.sta; end
            default: begin s.scl_lo = 1'b1; s.sda_lo = 1'b1; s.fin = 1'b1; end
          endcase
        end else begin
          case (st)
            2'd0: begin s.scl_lo = 1'b1; s.len = t.half; end
            2'd1: s.len = t.half + t.sta;
            2'd2: begin s.sda_lo = 1'b1; s.len = t.sta; end
            default: begin s.scl_lo = 1'b1; s.sda_lo = 1'b1; s.fin = 1'b1; end
          endcase
        end
      end
      OP_DATA: begin
        case (st)
          2'd0: begin s.scl_lo = 1'b1; s.sda_lo = sda_now; s.len = t.hold; end
          2'd1: begin s.scl_lo = 1'b1; s.sda_lo = !b; s.len = t.setup; end
          2'd2: begin s.sda_lo = !b; s.len = t.half; end
          default: begin s.scl_lo = 1'b1; s.sda_lo = !b; s.fin = 1'b1; end
        endcase
      end
      default: begin
        case (st)
          2'd0: begin s.scl_lo = 1'b1; s.sda_lo = 1'b1; s.len = t.half; end
          2'd1: begin s.sda_lo = 1'b1; s.len = LEN_W'(4); end
          default: s.fin = 1'b1;
        endcase
      end
    endcase
    return s;
  endfunction

  always_comb begin
    cur   = seg_of(op_q, rs_q, bit_q, sda_q, step_q, tim);
    nxt   = seg_of(op_q, rs_q, bit_q, sda_q, step_q + 2'd1, tim);
    first = seg_of(op_e'(cmd_op), scl_q, cmd_bit, sda_q, 2'd0, tim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rs_q   <= 1'b0;
      bit_q  <= 1'b0;
      op_q   <= OP_START;
      code_q <= '0;
      step_q <= '0;
      cnt_q  <= '0;
      scl_q  <= 1'b0;
      sda_q  <= 1'b0;
    end else if (!busy_q) begin
      if (accept) begin
        op_q   <= op_e'(cmd_op);
        bit_q  <= cmd_bit;
        rs_q   <= scl_q;
        code_q <= div_sel;
        step_q <= '0;
        cnt_q  <= '0;
        busy_q <= 1'b1;
        scl_q  <= first.scl_lo;
        sda_q  <= first.sda_lo;
      end
    end else if (cnt_q == cur.len - LEN_W'(1)) begin
      step_q <= step_q + 2'd1;
      cnt_q  <= '0;
      scl_q  <= nxt.scl_lo;
      sda_q  <= nxt.sda_lo;
      if (nxt.fin) busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + LEN_W'(1);
    end
  end

  logic [NLINE-1:0] raw_v, qual_v;
  assign raw_v = {scl_in, sda_in};
  for (genvar g = 0; g < NLINE; g++) begin : g_filt
    twi_glitch_filter #(.RATE_W(RATE_W)) u_filt (
      .clk(clk), .rst_n(rst_n), .rate(filt_rate),
      .raw(raw_v[g]), .qual(qual_v[g])
    );
  end
  assign scl_qual = qual_v[1];
  assign sda_qual = qual_v[0];

  // R8: an accepted command makes the block busy on the next cycle
  p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy_q);

  // R8: no line activity while idle
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !accept) |=> ($stable(scl_q) && $stable(sda_q)));

  // R3: data line moves only while the clock line is held low
  p_data_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && op_q == OP_DATA && !$stable(sda_q)) |-> (scl_q && $past(scl_q)));

  // R5: start edge on SDA happens with SCL released
  p_start_scl_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_q) && busy_q && op_q == OP_START) |-> !scl_q);

  // R7: stop releases SDA only after SCL is already released
  p_stop_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_q) && op_q[1]) |-> (!scl_q && !$past(scl_q)));
endmodule

// File: tb/sim_twi_bit_timer.sv
module sim_twi_bit_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] div_sel = '0;
  logic [5:0] filt_rate = 6'd3;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [1:0] cmd_op = 2'b00;
  logic       cmd_bit = 1'b0;
  logic       busy, scl_oe, sda_oe, scl_qual, sda_qual;
  logic       ext_scl = 1'b1, ext_sda = 1'b1;
  logic       scl_in, sda_in;

  assign scl_in = ~scl_oe & ext_scl;
  assign sda_in = ~sda_oe & ext_sda;

  always #2 clk = ~clk;

  twi_bit_timer u0 (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .filt_rate(filt_rate),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_bit(cmd_bit), .busy(busy), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .scl_in(scl_in), .sda_in(sda_in), .scl_qual(scl_qual), .sda_qual(sda_qual)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  typedef struct {
    bit    scl;
    bit    sda;
    bit    bz;
    int    len;
    string req;
  } exp_t;
  exp_t exq[$];
  int   mon_cnt = 0;

  task automatic push(bit s, bit d, bit bz, int n, string r);
    exp_t e;
    e.scl = s; e.sda = d; e.bz = bz; e.len = n; e.req = r;
    exq.push_back(e);
  endtask

  // monitor: compares each cycle against the head of the queue
  always @(negedge clk) begin
    if (exq.size() > 0) begin
      check(scl_oe === exq[0].scl && sda_oe === exq[0].sda &&
            busy === exq[0].bz && cmd_ready === !exq[0].bz, exq[0].req,
            {28'd0, scl_oe, sda_oe, busy, cmd_ready},
            {28'd0, exq[0].scl, exq[0].sda, exq[0].bz, !exq[0].bz});
      mon_cnt++;
      if (mon_cnt == exq[0].len) begin
        void'(exq.pop_front());
        mon_cnt = 0;
      end
    end
  end

  int t_half, t_hold, t_setup, t_sta;
  bit m_scl = 0, m_sda = 0;

  task automatic calc(input logic [5:0] c);
    int d, k, lim;
    d = (8 + 4 * c[5] + c[1:0]) * (1 << (c[4:2] + 5));
    t_half = d / 2;
    if ({c[5], c[1]} == 2'b10) k = 1;
    else if ({c[5], c[1]} == 2'b11) k = 2;
    else if ({c[5], c[1]} == 2'b00) k = 3;
    else k = 4;
    t_hold  = 8 + 16 * (1 << c[4:2]) * k;
    t_setup = t_half - t_hold;
    lim   = c[5] ? 9 : 16;
    t_sta = d / 16;
    while (t_sta >= lim) t_sta = t_sta / 2;
  endtask

  // driver: issue one command, push the expected waveform
  task automatic send(logic [1:0] op, bit b, bit spurious);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_bit = b;
    @(posedge clk);
    if (op == 2'b00 && !m_scl) begin
      push(0, 1, 1, t_sta, "R5");
      push(1, 1, 0, 1, "R8");
      m_scl = 1; m_sda = 1;
    end else if (op == 2'b00) begin
      push(1, 0, 1, t_half, "R6");
      push(0, 0, 1, t_half + t_sta, "R6");
      push(0, 1, 1, t_sta, "R6");
      push(1, 1, 0, 1, "R8");
      m_scl = 1; m_sda = 1;
    end else if (op == 2'b01) begin
      push(1, m_sda, 1, t_hold, "R3");
      push(1, !b, 1, t_setup, "R4");
      push(0, !b, 1, t_half, "R2");
      push(1, !b, 0, 1, "R8");
      m_scl = 1; m_sda = !b;
    end else begin
      push(1, 1, 1, t_half, "R7");
      push(0, 1, 1, 4, "R7");
      push(0, 0, 0, 1, "R8");
      m_scl = 0; m_sda = 0;
    end
    @(negedge clk);
    if (spurious) begin
      // R8: a command offered while busy must leave the sequence untouched
      cmd_op = 2'b10; cmd_bit = !b;
      repeat (3) @(negedge clk);
    end
    cmd_valid = 1'b0;
    wait (exq.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [5:0] codes [3];
    codes[0] = 6'b000000; codes[1] = 6'b100001; codes[2] = 6'b000110;
    repeat (2) @(negedge clk);
    // R1 during reset
    check(scl_oe === 0 && sda_oe === 0 && busy === 0 && cmd_ready === 1,
          "R1", {scl_oe, sda_oe, busy, cmd_ready}, 4'b0001);
    rst_n = 1'b1;
    @(negedge clk);
    check(scl_oe === 0 && sda_oe === 0 && busy === 0 && cmd_ready === 1 &&
          scl_qual === 1 && sda_qual === 1, "R1",
          {scl_oe, sda_oe, busy, cmd_ready, scl_qual, sda_qual}, 6'b000111);

    // R9: pulse of 2R=6 cycles rejected
    filt_rate = 6'd3;
    ext_sda = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(sda_qual === 1, "R9 short pulse", sda_qual, 1);
    end
    ext_sda = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(sda_qual === 1, "R9 short pulse", sda_qual, 1);
    end
    // R9: a held change appears on the 8th edge
    ext_sda = 1'b0;
    repeat (7) @(negedge clk);
    check(sda_qual === 1, "R9 before window", sda_qual, 1);
    @(negedge clk);
    check(sda_qual === 0, "R9 after window", sda_qual, 0);
    ext_sda = 1'b1;
    repeat (8) @(negedge clk);
    check(sda_qual === 1, "R9 rise", sda_qual, 1);
    // R9: rate 0 on SCL, change on the 2nd edge
    filt_rate = 6'd0;
    ext_scl = 1'b0;
    @(negedge clk);
    check(scl_qual === 1, "R9 rate0 early", scl_qual, 1);
    @(negedge clk);
    check(scl_qual === 0, "R9 rate0", scl_qual, 0);
    ext_scl = 1'b1;
    repeat (3) @(negedge clk);
    check(scl_qual === 1 && scl_oe === 0 && sda_oe === 0, "R8 idle",
          {scl_qual, scl_oe, sda_oe}, 3'b100);

    for (int c = 0; c < 3; c++) begin
      div_sel = codes[c];
      calc(codes[c]);
      send(2'b00, 0, 0);
      send(2'b01, 1, 1);
      send(2'b01, 0, 0);
      send(2'b01, 1, 0);
      send(2'b00, 0, 1);
      send(2'b01, 0, 0);
      send(2'b10, 0, 1);
      repeat (5) @(negedge clk);
      check(scl_oe === 0 && sda_oe === 0 && busy === 0, "R8 idle after stop",
            {scl_oe, sda_oe, busy}, 0);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule